// File: doc/BRIEF.md
# Indirect-Read 64-Bit Event Counter Bank

This block holds a bank of wide event counters that software programs and samples through a small register port. Each counter has its own configuration word. The configuration picks one line out of a wide vector of event inputs and sets how that line is turned into counts: once per cycle while the line is high, or once per rising or falling transition. The counters are 64 bits wide, so software does not need to sample them on a schedule to catch wraps.

One shared control word gates all counters. Counting happens only while both its enable bit and its start bit are set. Writing its clear bit zeroes every counter in that cycle, and the clear bit is not stored. Counters are read indirectly. Software writes a select value into a select register, then reads the upper word of that counter. The whole 64-bit value is frozen in a holding register at that moment. A later read of the lower word returns the frozen half, so a carry between the two reads cannot tear the value.

The register port is synchronous. A read issued on `reg_rd` at a clock edge presents its data on `reg_rdata` after that edge, and the data holds until the next read.

Top module: `evc_bank`

## Requirements
- R1: After reset, every counter is zero, the control, select and configuration registers read as zero, and `reg_rdata` is zero.
- R2: A counter changes only while the control word at byte offset 0x00 has both bit 0 (enable) and bit 1 (start) set. The control word reads back these two bits in positions 0 and 1, and all its other bits read as zero.
- R3: With bit 11 of its configuration clear (level mode), a running counter adds one for every clock cycle in which its selected event line is high.
- R4: With configuration bits 11 and 10 both set, a running counter adds one per low-to-high transition of its selected line, however long the line then stays high.
- R5: With configuration bit 11 set and bit 10 clear, a running counter adds one per high-to-low transition of its selected line.
- R6: Configuration bits [9:0] hold an event code that picks `evt_in[code]`. A counter reacts to no other line. A code of 0x200 or higher (beyond the input vector) never counts.
- R7: Writing the control word with bit 4 set clears every counter to zero in that same cycle. Bit 4 is not retained and reads back as zero.
- R8: Writing zero to the control word stops every counter, and each counter keeps its value while stopped.
- R9: Writing 8 + i to the select register at offset 0x04 picks counter i. Offset 0x08 returns bits [63:32] of counter i, and offset 0x0C returns bits [31:0].
- R10: A read at offset 0x08 latches all 64 bits of the selected counter. A following read at offset 0x0C returns the low half of that latched value, even if the counter has advanced in the meantime.
- R11: A select value outside 8 to 15 makes the reads at 0x08 and 0x0C both return zero.
- R12: The configuration register of counter i sits at byte offset 0x10 + 4*i and reads back its bits [11:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears on `reg_rdata` after the edge |
| reg_addr | input | 6 | Byte offset of the accessed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data, held until the next read |
| evt_in | input | EVT_W (512) | Event lines, one per event code |

## Verification
The hardest case to produce at the ports is a counter that advances between the upper-word read and the lower-word read. Without it, a design that reads the live counter on the low read looks just as correct as one that returns the latched value. The stimulus holds a level-mode event high without a break while the two reads are issued back to back. The live counter therefore moves several steps past the latched value, and the expected low word is worked out from the cycle in which the upper read was taken. A carry out of the low 32 bits cannot be reached by counting in a short run, so the advancing low bits stand in for it.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int ID_W   = 10;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] A_CTRL = 6'h00;
  localparam logic [ADDR_W-1:0] A_SEL  = 6'h04;
  localparam logic [ADDR_W-1:0] A_HI   = 6'h08;
  localparam logic [ADDR_W-1:0] A_LO   = 6'h0C;
  localparam logic [ADDR_W-1:0] A_CFG0 = 6'h10;

  localparam int SEL_BASE = 8;
  localparam int CTL_EN   = 0;
  localparam int CTL_GO   = 1;
  localparam int CTL_CLR  = 4;

  // Field order follows the bit positions: [11] edge, [10] rising, [9:0] code.
  typedef struct packed {
    logic            edge_mode;
    logic            rise;
    logic [ID_W-1:0] id;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  // Qualify the current and previous sample of an event line.
  function automatic logic evt_hit(input cfg_t c, input logic cur, input logic prev);
    if (c.edge_mode) return c.rise ? (cur & ~prev) : (~cur & prev);
    return cur;
  endfunction

  // True when a select value addresses one of n counters.
  function automatic logic sel_in_window(input logic [DATA_W-1:0] s, input int n);
    return (s >= DATA_W'(SEL_BASE)) && (s < DATA_W'(SEL_BASE + n));
  endfunction
endpackage

// File: rtl/evc_regfile.sv
module evc_regfile import evc_pkg::*; #(
  parameter int NUM_CNT = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  output cfg_t [NUM_CNT-1:0]      cfg_q,
  output logic [NUM_CNT-1:0]      cfg_we,
  output logic                    en_q,
  output logic                    go_q,
  output logic                    clr,
  output logic [DATA_W-1:0]       sel_q,
  output logic [DATA_W-1:0]       view
);
  logic ctrl_we;
  logic sel_we;
  logic [NUM_CNT-1:0] cfg_hit;

  assign ctrl_we = wr && (addr == A_CTRL);
  assign sel_we  = wr && (addr == A_SEL);
  assign clr     = ctrl_we && wdata[CTL_CLR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      go_q  <= 1'b0;
      sel_q <= '0;
    end else begin
      if (ctrl_we) begin
        en_q <= wdata[CTL_EN];
        go_q <= wdata[CTL_GO];
      end
      if (sel_we) sel_q <= wdata;
    end
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cfg
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(int'(A_CFG0) + 4 * i);
    cfg_t r;
    assign cfg_hit[i] = (addr == MY_ADDR);
    assign cfg_we[i]  = wr && cfg_hit[i];
    always_ff @(posedge clk) begin
      if (!rst_n)         r <= '0;
      else if (cfg_we[i]) r <= cfg_t'(wdata[CFG_W-1:0]);
    end
    assign cfg_q[i] = r;
  end

  always_comb begin
    view = '0;
    if (addr == A_CTRL) begin
      view[CTL_EN] = en_q;
      view[CTL_GO] = go_q;
    end else if (addr == A_SEL) begin
      view = sel_q;
    end
    for (int i = 0; i < NUM_CNT; i++) begin
      if (cfg_hit[i]) view = DATA_W'(cfg_q[i]);
    end
  end
endmodule

// File: rtl/evc_counter.sv
module evc_counter import evc_pkg::*; #(
  parameter int CNT_W = 64,
  parameter int EVT_W = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cfg_t             cfg,
  input  logic [EVT_W-1:0] evt_in,
  input  logic             run,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             inc
);
  localparam int IDX_W = (EVT_W > 1) ? $clog2(EVT_W) : 1;

  logic in_range;
  logic cur;
  logic prev_q;

  assign in_range = (int'(cfg.id) < EVT_W);
  assign cur      = in_range ? evt_in[IDX_W'(cfg.id)] : 1'b0;
  assign inc      = run && evt_hit(cfg, cur, prev_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cnt    <= '0;
    end else begin
      prev_q <= cur;
      if (clr)      cnt <= '0;
      else if (inc) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/evc_readout.sv
module evc_readout import evc_pkg::*; #(
  parameter int NUM_CNT = 8,
  parameter int CNT_W   = 64
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            rd,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [DATA_W-1:0]               sel,
  input  logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_all,
  input  logic [DATA_W-1:0]               view,
  output logic [DATA_W-1:0]               rdata,
  output logic                            sel_ok
);
  localparam int SLOT_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;

  logic [SLOT_W-1:0] slot;
  logic [CNT_W-1:0]  live;
  logic [CNT_W-1:0]  hold_q;

  assign sel_ok = sel_in_window(sel, NUM_CNT);
  assign slot   = SLOT_W'(sel - DATA_W'(SEL_BASE));
  assign live   = sel_ok ? cnt_all[slot] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      rdata  <= '0;
    end else if (rd) begin
      if (addr == A_HI) begin
        hold_q <= live;
        rdata  <= DATA_W'(live[CNT_W-1:DATA_W]);
      end else if (addr == A_LO) begin
        rdata  <= sel_ok ? hold_q[DATA_W-1:0] : '0;
      end else begin
        rdata  <= view;
      end
    end
  end
endmodule

// File: rtl/evc_bank.sv
module evc_bank import evc_pkg::*; #(
  parameter int NUM_CNT = 8,
  parameter int CNT_W   = 64,
  parameter int EVT_W   = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [EVT_W-1:0]  evt_in
);
  cfg_t [NUM_CNT-1:0]            cfg_q;
  logic [NUM_CNT-1:0]            cfg_we;
  logic                          en_q;
  logic                          go_q;
  logic                          clr;
  logic                          run;
  logic [DATA_W-1:0]             sel_q;
  logic [DATA_W-1:0]             view;
  logic                          sel_ok;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all;
  logic [NUM_CNT-1:0]            inc;
  logic [NUM_CNT-1:0]            edge_vec;

  assign run = en_q && go_q;

  evc_regfile #(.NUM_CNT(NUM_CNT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .cfg_q(cfg_q), .cfg_we(cfg_we), .en_q(en_q), .go_q(go_q), .clr(clr),
    .sel_q(sel_q), .view(view)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    assign edge_vec[i] = cfg_q[i].edge_mode;
    evc_counter #(.CNT_W(CNT_W), .EVT_W(EVT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .cfg(cfg_q[i]), .evt_in(evt_in),
      .run(run), .clr(clr), .cnt(cnt_all[i]), .inc(inc[i])
    );
  end

  evc_readout #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd(reg_rd), .addr(reg_addr), .sel(sel_q),
    .cnt_all(cnt_all), .view(view), .rdata(reg_rdata), .sel_ok(sel_ok)
  );
endmodule

// File: rtl/evc_bank_chk.sv
module evc_bank_chk import evc_pkg::*; #(
  parameter int NUM_CNT = 8,
  parameter int CNT_W   = 64
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          reg_rd,
  input logic [ADDR_W-1:0]             reg_addr,
  input logic [DATA_W-1:0]             reg_rdata,
  input logic                          run,
  input logic                          clr,
  input logic                          sel_ok,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all,
  input logic [NUM_CNT-1:0]            inc,
  input logic [NUM_CNT-1:0]            edge_vec,
  input logic [NUM_CNT-1:0]            cfg_we
);
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_all == '0))
    else $error("clear pulse did not zero the counters");

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(cnt_all))
    else $error("counter moved while not running");

  assert_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (reg_addr == A_HI || reg_addr == A_LO) && !sel_ok) |=> (reg_rdata == '0))
    else $error("out-of-window select returned data");

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (cnt_all[i] == $past(cnt_all[i]) || cnt_all[i] == $past(cnt_all[i]) + CNT_W'(1)))
      else $error("counter stepped by more than one");

    assert_edge_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_vec[i] && inc[i] && !cfg_we[i]) |=> !inc[i])
      else $error("edge mode counted two cycles in a row");
  end
endmodule

bind evc_bank evc_bank_chk #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .run(run), .clr(clr), .sel_ok(sel_ok), .cnt_all(cnt_all), .inc(inc),
  .edge_vec(edge_vec), .cfg_we(cfg_we)
);

// File: tb/evc_bank_test.sv
`timescale 1ns/100ps
module evc_bank_test;
  import evc_pkg::*;
  localparam int NUM_CNT = 8;
  localparam int CNT_W   = 64;
  localparam int EVT_W   = 512;
  localparam int E_LVL   = 61;   // code 0x3D
  localparam int E_RISE  = 101;  // code 0x65
  localparam int E_FALL  = 261;  // code 0x105

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic reg_rd = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic [EVT_W-1:0]  evt = '0;

  always #2.5 clk = ~clk;

  evc_bank #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .EVT_W(EVT_W)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt)
  );

  int checks = 0;
  int fails = 0;
  logic [DATA_W-1:0] exp_q[$];
  string tag_q[$];
  logic rd_seen = 1'b0;

  always @(posedge clk) rd_seen <= reg_rd;

  // Monitor: pops the expected word for each completed read.
  always @(negedge clk) begin
    if (rd_seen) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL scoreboard: actual=%h expected=<queued item>", reg_rdata);
      end else begin
        logic [DATA_W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          fails++;
          $display("FAIL %s: actual=%h expected=%h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic wr_reg(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e, input string t);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic read_cnt(input int s, input logic [CNT_W-1:0] e, input string t);
    wr_reg(A_SEL, DATA_W'(s));
    rd_reg(A_HI, e[CNT_W-1:DATA_W], t);
    rd_reg(A_LO, e[DATA_W-1:0], t);
  endtask

  task automatic hold_evt(input int b, input int n);
    @(negedge clk); evt[b] = 1'b1;
    repeat (n) @(negedge clk);
    evt[b] = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (reg_rdata !== '0) begin
      fails++;
      $display("FAIL R1 rdata after reset: actual=%h expected=%h", reg_rdata, 32'h0);
    end
    rd_reg(A_CTRL, 32'h0, "R1 ctrl reset");
    rd_reg(A_SEL, 32'h0, "R1 select reset");
    rd_reg(A_CFG0, 32'h0, "R1 cfg reset");
    read_cnt(8, 64'h0, "R1 counter reset");

    // Configure: c0 level on 0x3D, c1 rising on 0x65, c2 falling on 0x105, c3 code 0x200.
    wr_reg(6'h10, 32'h0000_003D);
    wr_reg(6'h14, 32'h0000_0C65);
    wr_reg(6'h18, 32'h0000_0905);
    wr_reg(6'h1C, 32'h0000_0200);
    rd_reg(6'h14, 32'h0000_0C65, "R12 cfg1 readback");
    rd_reg(6'h1C, 32'h0000_0200, "R12 cfg3 readback");

    // R2: enable alone, start alone.
    wr_reg(A_CTRL, 32'h1);
    hold_evt(E_LVL, 4);
    read_cnt(8, 64'd0, "R2 enable only");
    wr_reg(A_CTRL, 32'h2);
    hold_evt(E_LVL, 4);
    read_cnt(8, 64'd0, "R2 start only");
    wr_reg(A_CTRL, 32'hFFFF_FFE3);
    rd_reg(A_CTRL, 32'h3, "R2 ctrl readback");

    // R3: level count.
    hold_evt(E_LVL, 6);
    read_cnt(8, 64'd6, "R3 level count");

    // R4/R5: same waveform on two lines; 3 rising and 3 falling transitions.
    @(negedge clk); evt[E_RISE] = 1'b1; evt[E_FALL] = 1'b1;
    repeat (3) @(negedge clk); evt[E_RISE] = 1'b0; evt[E_FALL] = 1'b0;
    repeat (2) @(negedge clk); evt[E_RISE] = 1'b1; evt[E_FALL] = 1'b1;
    @(negedge clk);            evt[E_RISE] = 1'b0; evt[E_FALL] = 1'b0;
    @(negedge clk);            evt[E_RISE] = 1'b1; evt[E_FALL] = 1'b1;
    repeat (4) @(negedge clk); evt[E_RISE] = 1'b0; evt[E_FALL] = 1'b0;
    repeat (2) @(negedge clk);
    read_cnt(9,  64'd3, "R4 rising edges");
    read_cnt(10, 64'd3, "R5 falling edges");
    read_cnt(8,  64'd6, "R6 other lines ignored");

    // R6/R9: all lines high for 3 cycles.
    @(negedge clk); evt = '1;
    repeat (3) @(negedge clk); evt = '0;
    repeat (2) @(negedge clk);
    read_cnt(11, 64'd0, "R6 code beyond vector");
    read_cnt(13, 64'd3, "R9 counter5 on code 0");
    read_cnt(8,  64'd9, "R9 counter0");
    read_cnt(9,  64'd4, "R4 rising after burst");
    read_cnt(10, 64'd4, "R5 falling after burst");

    // R8: stop holds values.
    wr_reg(A_CTRL, 32'h0);
    hold_evt(E_LVL, 5);
    read_cnt(8, 64'd9, "R8 stopped counter holds");

    // R10: counter advances between the two halves.
    wr_reg(A_SEL, 32'd8);
    wr_reg(A_CTRL, 32'h3);
    @(negedge clk); evt[E_LVL] = 1'b1;
    rd_reg(A_HI, 32'h0, "R10 high word");
    rd_reg(A_LO, 32'd10, "R10 low word from latch");
    @(negedge clk); evt[E_LVL] = 1'b0;

    // R7: clear pulse.
    wr_reg(A_CTRL, 32'h10);
    read_cnt(8,  64'd0, "R7 counter0 cleared");
    read_cnt(13, 64'd0, "R7 counter5 cleared");
    rd_reg(A_CTRL, 32'h0, "R7 ctrl after clear");
    wr_reg(A_CTRL, 32'h13);
    rd_reg(A_CTRL, 32'h3, "R7 clear bit not kept");
    hold_evt(E_LVL, 2);
    read_cnt(8, 64'd2, "R7 counting after clear");

    // R11: selects outside the window.
    read_cnt(7,  64'd0, "R11 select 7");
    read_cnt(16, 64'd0, "R11 select 16");
    read_cnt(32'h108, 64'd0, "R11 select 0x108");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard drain: actual=%0d expected=0", exp_q.size());
    end
    summary();
  end
endmodule